// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block maps a 16-bit virtual address to a wider physical address for a processor with three privilege modes: kernel, supervisor and user. The virtual space is cut into eight equal segments of 8 KB. Each mode owns two banks of eight segments, one for instruction references and one for data references. Each segment is described by a base register and a descriptor register, and all of this state is held in on-chip registers. A segment's descriptor gives a length in 64-byte blocks, a growth direction, an access code and a dirty flag. The dirty flag is set by the block itself whenever a write into that segment succeeds.

Software loads the segment registers and two control registers through a one-cycle write port, and reads them back through a combinational read port. The caller presents an access with its mode, an instruction/data flag and a read/write flag. Fetches of immediate operands and absolute addresses are flagged as instruction references. One cycle later the block returns the physical address, or a one-cycle fault strobe if the access must be aborted. A three-state controller governs the fault record. In state OFF, translation is disabled and addresses pass through. In state RUN, translation is active and the record is open. In state HELD, translation is active and the first fault's record is frozen. The named transitions are:
- `enable` (OFF to RUN, or OFF to HELD if a record is still held);
- `disable` (RUN or HELD to OFF);
- `trap` (RUN to HELD on a faulting access);
- `release` (HELD to RUN on a clear request).

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, translation is off, the control/status word, split bits, fault address and every segment register read as zero, and `fault` and `out_valid` are low.
- R2: While translation is off (state OFF), an access returns `pa` equal to the zero-extended `va` one cycle after `acc_valid`, and `fault` stays low.
- R3: While translation is on, `va[15:13]` selects the segment and `pa` = base×64 + `va[12:0]`, registered one cycle after `acc_valid`.
- R4: For a segment with direction bit 0 (grows upward), an access whose block number `va[12:6]` exceeds the length field faults. Block numbers at or below the length field pass.
- R5: For a segment with direction bit 1 (grows downward), an access whose block number is below the length field faults. Block numbers at or above the length field pass.
- R6: The access code has two bits: bit 0 set means readable, and the value 3 means writable. Any access to a segment with bit 0 clear faults with the no-access flag. A write to a segment with code 1 faults with the read-only flag.
- R7: `acc_mode` 0 selects the kernel registers, 1 selects supervisor, and 2 or 3 selects user. Each mode translates only through its own registers.
- R8: Split bit k enables separate data space for mode k (0 kernel, 1 supervisor, 2 user). With the bit clear, every access in that mode uses the instruction bank. With the bit set, accesses with `acc_data`=1 use the data bank.
- R9: A successful translated write sets descriptor bit 6 (dirty) of the segment used. A software write to a descriptor clears its dirty bit. A faulted write leaves the dirty bit unchanged.
- R10: In state RUN, a faulting access moves the controller to HELD and records the following: bit 15 no-access, bit 14 length, bit 13 read-only, bits 7:6 mode index, bit 5 data bank, bits 4:2 segment, and `instr_addr` into the fault-address register.
- R11: In state HELD, further faults still pulse `fault` but leave the status and fault address unchanged until a control write with bit 1 (clear) set. The clear zeroes the whole record.
- R12: A control write with bit 0 = 0 enters OFF (the record is kept). A control write with bit 0 = 1 from OFF enters HELD if a record is held and clear is 0, and otherwise enters RUN. Status bit 0 reads 1 exactly when the state is not OFF.
- R13: Register address `{mode[1:0], data, base, seg[2:0]}` with mode 0–2 selects a segment register. Mode field 3 selects control (low bits 0), split (1) and fault address (2). The descriptor layout is length 14:8, dirty 6, direction 3, access 1:0. Base registers read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| va | input | 16 | Virtual address |
| acc_mode | input | 2 | Processor mode code |
| acc_data | input | 1 | 1 = data reference, 0 = instruction reference |
| acc_write | input | 1 | 1 = write, 0 = read |
| instr_addr | input | 16 | Address of the instruction making the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 7 | Register read address |
| reg_rdata | output | 16 | Register read data (combinational) |
| out_valid | output | 1 | Result valid, one cycle after `acc_valid` |
| pa | output | BASE_W+6 | Physical address |
| fault | output | 1 | One-cycle abort strobe |
| mm_status | output | 16 | Control/status word |

## Verification
A corrupted base or a wrong bank choice shows as a wrong `pa` on the cycle right after the access. Such errors are caught by sweeping every mode, bank and segment under each split setting. An off-by-one in the length compare shows only at the block next to the limit. The bench therefore sweeps all 128 blocks for low, middle and full lengths in both directions. A controller stuck in the wrong state shows up in the status word at the next register read: a record that changes while held, a clear that does not empty it, or an enable bit that disagrees with pass-through behaviour.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int SEGS_PER_BANK = 8;
    localparam int BANKS         = 2;
    localparam int MODES         = 3;
    localparam int SEG_PAIRS     = SEGS_PER_BANK * BANKS * MODES;
    localparam int OFF_W         = 13;
    localparam int BLK_W         = 7;

    typedef enum logic [1:0] {
        XS_OFF  = 2'd0,
        XS_RUN  = 2'd1,
        XS_HELD = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic [BLK_W-1:0] len;
        logic             dirty;
        logic             down;
        logic [1:0]       acf;
    } seg_desc_t;

    function automatic logic [1:0] mode_index(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [15:0] desc_word(input seg_desc_t d);
        return {1'b0, d.len, 1'b0, d.dirty, 2'b00, d.down, 1'b0, d.acf};
    endfunction

endpackage

// File: rtl/segx_regs.sv
module segx_regs
    import segx_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [5:0]        sel_idx,
    input  logic              set_dirty,
    input  logic [6:0]        rd_addr,
    output seg_desc_t         sel_desc,
    output logic [BASE_W-1:0] sel_base,
    output logic [15:0]       rd_data
);

    seg_desc_t         desc_q [SEG_PAIRS];
    logic [BASE_W-1:0] base_q [SEG_PAIRS];

    logic       wr_seg_space;
    logic [5:0] wr_idx;
    logic [5:0] rd_idx;

    assign wr_seg_space = (wr_addr[6:5] != 2'd3);
    assign wr_idx       = {wr_addr[6:5], wr_addr[4], wr_addr[2:0]};
    assign rd_idx       = {rd_addr[6:5], rd_addr[4], rd_addr[2:0]};

    generate
        for (genvar i = 0; i < SEG_PAIRS; i++) begin : g_pair
            localparam logic [5:0] IDX = 6'(i);
            logic hit;
            assign hit = wr_en && wr_seg_space && (wr_idx == IDX);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    desc_q[i] <= '0;
                    base_q[i] <= '0;
                end else begin
                    if (hit && !wr_addr[3]) begin
                        desc_q[i].len   <= wr_data[14:8];
                        desc_q[i].dirty <= 1'b0;
                        desc_q[i].down  <= wr_data[3];
                        desc_q[i].acf   <= wr_data[1:0];
                    end else if (set_dirty && (sel_idx == IDX)) begin
                        desc_q[i].dirty <= 1'b1;
                    end
                    if (hit && wr_addr[3]) begin
                        base_q[i] <= wr_data[BASE_W-1:0];
                    end
                end
            end
        end
    endgenerate

    assign sel_desc = desc_q[sel_idx];
    assign sel_base = base_q[sel_idx];

    always_comb begin
        rd_data = '0;
        if (rd_addr[6:5] != 2'd3) begin
            rd_data = rd_addr[3] ? 16'(base_q[rd_idx]) : desc_word(desc_q[rd_idx]);
        end
    end

endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
#(
    parameter  int BASE_W = 16,
    localparam int PA_W   = BASE_W + 6
) (
    input  seg_desc_t         desc,
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_write,
    output logic [PA_W-1:0]   pa,
    output logic              f_nores,
    output logic              f_len,
    output logic              f_ro
);

    logic [BLK_W-1:0] blk;

    assign blk     = offset[OFF_W-1:6];
    assign f_len   = desc.down ? (blk < desc.len) : (blk > desc.len);
    assign f_nores = !desc.acf[0];
    assign f_ro    = desc.acf[0] && !desc.acf[1] && is_write;
    assign pa      = {base, 6'b0} + PA_W'(offset);

endmodule

// File: rtl/segx_fsm.sv
module segx_fsm
    import segx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        ctrl_en,
    input  logic        ctrl_clr,
    input  logic        flt_take,
    input  logic        fl_nores,
    input  logic        fl_len,
    input  logic        fl_ro,
    input  logic [1:0]  fl_mode,
    input  logic        fl_dsp,
    input  logic [2:0]  fl_seg,
    input  logic [15:0] fl_ia,
    output logic        xl_on,
    output logic [15:0] status,
    output logic [15:0] fault_ia
);

    xl_state_e state_q, state_d;

    logic       r_nores, r_len, r_ro, r_dsp;
    logic [1:0] r_mode;
    logic [2:0] r_seg;
    logic       any_reason;

    assign any_reason = r_nores || r_len || r_ro;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_OFF: begin
                if (ctrl_wr && ctrl_en)
                    state_d = (any_reason && !ctrl_clr) ? XS_HELD : XS_RUN;
            end
            XS_RUN: begin
                if (ctrl_wr)       state_d = ctrl_en ? XS_RUN : XS_OFF;
                else if (flt_take) state_d = XS_HELD;
            end
            XS_HELD: begin
                if (ctrl_wr) begin
                    if (!ctrl_en)     state_d = XS_OFF;
                    else if (ctrl_clr) state_d = XS_RUN;
                end
            end
            default: state_d = XS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_nores  <= 1'b0;
            r_len    <= 1'b0;
            r_ro     <= 1'b0;
            r_dsp    <= 1'b0;
            r_mode   <= '0;
            r_seg    <= '0;
            fault_ia <= '0;
        end else if (ctrl_wr && ctrl_clr) begin
            r_nores  <= 1'b0;
            r_len    <= 1'b0;
            r_ro     <= 1'b0;
            r_dsp    <= 1'b0;
            r_mode   <= '0;
            r_seg    <= '0;
            fault_ia <= '0;
        end else if (state_q == XS_RUN && flt_take && !ctrl_wr) begin
            r_nores  <= fl_nores;
            r_len    <= fl_len;
            r_ro     <= fl_ro;
            r_dsp    <= fl_dsp;
            r_mode   <= fl_mode;
            r_seg    <= fl_seg;
            fault_ia <= fl_ia;
        end
    end

    assign xl_on  = (state_q != XS_OFF);
    assign status = {r_nores, r_len, r_ro, 5'b0, r_mode, r_dsp, r_seg, 1'b0, xl_on};

    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_HELD && !ctrl_wr) |=> ($stable(status) && $stable(fault_ia)));

    p_held_has_reason_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_HELD) |-> any_reason);

    p_trap_enters_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_RUN && flt_take && !ctrl_wr) |=> (state_q == XS_HELD));

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import segx_pkg::*;
#(
    parameter  int BASE_W = 16,
    localparam int PA_W   = BASE_W + 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [15:0]     va,
    input  logic [1:0]      acc_mode,
    input  logic            acc_data,
    input  logic            acc_write,
    input  logic [15:0]     instr_addr,
    input  logic            reg_wr,
    input  logic [6:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    input  logic [6:0]      reg_raddr,
    output logic [15:0]     reg_rdata,
    output logic            out_valid,
    output logic [PA_W-1:0] pa,
    output logic            fault,
    output logic [15:0]     mm_status
);

    localparam logic [6:0] A_CTRL  = 7'h60;
    localparam logic [6:0] A_SPLIT = 7'h61;
    localparam logic [6:0] A_FADDR = 7'h62;

    logic [2:0]        split_q;
    logic [1:0]        midx;
    logic              dsel;
    logic [5:0]        sel_idx;
    seg_desc_t         sel_desc;
    logic [BASE_W-1:0] sel_base;
    logic [PA_W-1:0]   chk_pa;
    logic              f_nores, f_len, f_ro, any_f;
    logic              xl_on, set_dirty, flt_take, ctrl_wr;
    logic [15:0]       seg_rdata, status, fault_ia;

    assign midx    = mode_index(acc_mode);
    assign dsel    = acc_data && split_q[midx];
    assign sel_idx = {midx, dsel, va[15:13]};
    assign any_f   = f_nores || f_len || f_ro;
    assign set_dirty = acc_valid && xl_on && acc_write && !any_f;
    assign flt_take  = acc_valid && xl_on && any_f;
    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);

    segx_regs #(.BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .sel_idx(sel_idx), .set_dirty(set_dirty), .rd_addr(reg_raddr),
        .sel_desc(sel_desc), .sel_base(sel_base), .rd_data(seg_rdata)
    );

    segx_check #(.BASE_W(BASE_W)) u_check (
        .desc(sel_desc), .base(sel_base), .offset(va[OFF_W-1:0]),
        .is_write(acc_write), .pa(chk_pa),
        .f_nores(f_nores), .f_len(f_len), .f_ro(f_ro)
    );

    segx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_en(reg_wdata[0]), .ctrl_clr(reg_wdata[1]),
        .flt_take(flt_take),
        .fl_nores(f_nores), .fl_len(f_len), .fl_ro(f_ro),
        .fl_mode(midx), .fl_dsp(dsel), .fl_seg(va[15:13]), .fl_ia(instr_addr),
        .xl_on(xl_on), .status(status), .fault_ia(fault_ia)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           split_q <= '0;
        else if (reg_wr && reg_addr == A_SPLIT) split_q <= reg_wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pa        <= '0;
            fault     <= 1'b0;
        end else begin
            out_valid <= acc_valid;
            fault     <= flt_take;
            if (acc_valid) pa <= xl_on ? chk_pa : PA_W'(va);
        end
    end

    always_comb begin
        reg_rdata = seg_rdata;
        if (reg_raddr[6:5] == 2'd3) begin
            unique case (reg_raddr)
                A_CTRL:  reg_rdata = status;
                A_SPLIT: reg_rdata = {13'b0, split_q};
                A_FADDR: reg_rdata = fault_ia;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign mm_status = status;

    p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !xl_on) |=> (pa == PA_W'($past(va))));

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !xl_on) |=> !fault);

    p_fault_has_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> out_valid);

    p_enable_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=> !mm_status[0]);

endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;

    localparam int BASE_W = 16;
    localparam int PA_W   = BASE_W + 6;
    localparam logic [6:0] A_CTRL  = 7'h60;
    localparam logic [6:0] A_SPLIT = 7'h61;
    localparam logic [6:0] A_FADDR = 7'h62;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic [15:0]     va = '0;
    logic [1:0]      acc_mode = '0;
    logic            acc_data = 1'b0;
    logic            acc_write = 1'b0;
    logic [15:0]     instr_addr = '0;
    logic            reg_wr = 1'b0;
    logic [6:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [6:0]      reg_raddr = '0;
    logic [15:0]     reg_rdata;
    logic            out_valid;
    logic [PA_W-1:0] pa;
    logic            fault;
    logic [15:0]     mm_status;

    int n_chk = 0;
    int n_fail = 0;
    int m_base [48];
    logic [15:0] rv;
    int held;

    always #4 clk = ~clk;

    seg_xlate_top #(.BASE_W(BASE_W)) i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .va(va),
        .acc_mode(acc_mode), .acc_data(acc_data), .acc_write(acc_write),
        .instr_addr(instr_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .pa(pa), .fault(fault), .mm_status(mm_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sidx(input int m, input int d, input int s);
        return m * 16 + d * 8 + s;
    endfunction

    function automatic logic [6:0] saddr(input int m, input int d, input int b, input int s);
        return 7'((m << 5) | (d << 4) | (b << 3) | s);
    endfunction

    task automatic wreg(input logic [6:0] a, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = 16'(data);
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [6:0] a);
        reg_raddr = a;
        #1;
        rv = reg_rdata;
    endtask

    task automatic acc(input int v, input int m, input int d, input int w, input int ia);
        @(negedge clk);
        va = 16'(v); acc_mode = 2'(m); acc_data = d[0]; acc_write = w[0];
        instr_addr = 16'(ia); acc_valid = 1'b1;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rreg(A_CTRL);             check("R1 ctrl", rv, 0);
        rreg(A_SPLIT);            check("R1 split", rv, 0);
        rreg(A_FADDR);            check("R1 faddr", rv, 0);
        rreg(saddr(2, 1, 1, 7));  check("R1 base", rv, 0);
        rreg(saddr(1, 0, 0, 3));  check("R1 desc", rv, 0);
        check("R1 fault", fault, 0);
        check("R1 valid", out_valid, 0);

        // R2: pass-through while off
        for (int k = 0; k < 64; k++) begin
            acc((k * 1031 + 7) & 16'hFFFF, k % 4, k % 2, (k / 2) % 2, 0);
            check("R2 pa", pa, (k * 1031 + 7) & 16'hFFFF);
            check("R2 fault", fault, 0);
        end

        // R13: load all segment registers
        for (int m = 0; m < 3; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 8; s++) begin
                    m_base[sidx(m, d, s)] = (sidx(m, d, s) * 16'h0457 + 16'h0100) & 16'hFFFF;
                    wreg(saddr(m, d, 1, s), m_base[sidx(m, d, s)]);
                    wreg(saddr(m, d, 0, s), (127 << 8) | 3);
                end
        rreg(saddr(1, 1, 1, 4)); check("R13 base readback", rv, m_base[sidx(1, 1, 4)]);
        rreg(saddr(2, 0, 0, 6)); check("R13 desc readback", rv, (127 << 8) | 3);

        wreg(A_CTRL, 1);
        rreg(A_CTRL); check("R12 enable", rv, 1);

        // R3 R7 R8: split off, both flags use instruction bank
        for (int m = 0; m < 3; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 8; s++)
                    for (int o = 0; o < 3; o++) begin
                        int off;
                        int code;
                        off  = (o == 0) ? 0 : (o == 1) ? 16'h00A5 : 16'h1FFF;
                        code = (m == 2) ? 2 + (s % 2) : m;
                        acc((s << 13) | off, code, d, 0, 0);
                        check("R3 R7 R8 pa", pa, m_base[sidx(m, 0, s)] * 64 + off);
                        check("R3 fault", fault, 0);
                        check("R3 valid", out_valid, 1);
                    end

        // R8: each split setting
        for (int t = 0; t < 4; t++) begin
            int sp;
            sp = (t == 3) ? 7 : (1 << t);
            wreg(A_SPLIT, sp);
            rreg(A_SPLIT); check("R8 split readback", rv, sp);
            for (int m = 0; m < 3; m++)
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < 8; s += 3) begin
                        int eb;
                        eb = (d == 1 && ((sp >> m) & 1) == 1) ? 1 : 0;
                        acc((s << 13) | 16'h0123, m, d, 0, 0);
                        check("R8 R7 bank pa", pa, m_base[sidx(m, eb, s)] * 64 + 16'h0123);
                    end
        end
        wreg(A_SPLIT, 0);

        // R4 R5: length sweep over all blocks
        for (int dn = 0; dn < 2; dn++)
            for (int li = 0; li < 3; li++) begin
                int len;
                len = (li == 0) ? 0 : (li == 1) ? 37 : 127;
                wreg(saddr(0, 0, 0, 2), (len << 8) | (dn << 3) | 3);
                for (int b = 0; b < 128; b++) begin
                    int off;
                    int ef;
                    off = (b << 6) | (b & 63);
                    ef  = dn ? (b < len) : (b > len);
                    acc((2 << 13) | off, 0, 0, 0, 0);
                    if (dn == 0) check("R4 up length", fault, ef);
                    else         check("R5 down length", fault, ef);
                    if (ef == 0) check("R4 R5 pa", pa, m_base[2] * 64 + off);
                end
            end
        wreg(saddr(0, 0, 0, 2), (127 << 8) | 3);
        wreg(A_CTRL, 3);

        // R6 R9: access codes and dirty flag
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 0);
        acc((3 << 13) | 16'h40, 0, 0, 0, 0); check("R6 code0 read", fault, 1);
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 2);
        acc((3 << 13) | 16'h40, 0, 0, 0, 0); check("R6 code2 read", fault, 1);
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 1);
        acc((3 << 13) | 16'h40, 0, 0, 0, 0); check("R6 code1 read", fault, 0);
        check("R6 code1 pa", pa, m_base[3] * 64 + 16'h40);
        acc((3 << 13) | 16'h40, 0, 0, 1, 0); check("R6 code1 write", fault, 1);
        rreg(saddr(0, 0, 0, 3)); check("R9 faulted write no dirty", rv, (127 << 8) | 1);
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 3);
        rreg(saddr(0, 0, 0, 3)); check("R9 clean after sw write", rv, (127 << 8) | 3);
        acc((3 << 13) | 16'h40, 0, 0, 1, 0); check("R6 code3 write", fault, 0);
        rreg(saddr(0, 0, 0, 3)); check("R9 dirty set", rv, (127 << 8) | 16'h40 | 3);
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 3);
        rreg(saddr(0, 0, 0, 3)); check("R9 dirty cleared", rv, (127 << 8) | 3);

        wreg(A_CTRL, 3);
        rreg(A_CTRL);  check("R11 clear status", rv, 1);
        rreg(A_FADDR); check("R11 clear faddr", rv, 0);

        // R10: capture no-access fault
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 0);
        acc((3 << 13) | 16'h80, 0, 0, 0, 16'h1234);
        check("R10 strobe", fault, 1);
        held = 1 | (3 << 2) | (1 << 15);
        rreg(A_CTRL);  check("R10 status", rv, held);
        check("R10 status port", mm_status, held);
        rreg(A_FADDR); check("R10 faddr", rv, 16'h1234);

        // R11: frozen while held
        wreg(saddr(2, 0, 0, 5), (0 << 8) | 3);
        acc((5 << 13) | (4 << 6), 3, 0, 0, 16'h5555);
        check("R11 strobe while held", fault, 1);
        rreg(A_CTRL);  check("R11 status frozen", rv, held);
        rreg(A_FADDR); check("R11 faddr frozen", rv, 16'h1234);

        // R12: disable keeps record, pass-through, re-enable returns to held
        wreg(A_CTRL, 0);
        rreg(A_CTRL); check("R12 off keeps record", rv, held & 16'hFFFE);
        acc(16'hABCD, 0, 0, 1, 0);
        check("R12 off pass pa", pa, 16'hABCD);
        check("R12 off no fault", fault, 0);
        wreg(A_CTRL, 1);
        rreg(A_CTRL); check("R12 enable to held", rv, held);
        acc((5 << 13) | (4 << 6), 2, 0, 0, 16'h7777);
        check("R12 held strobe", fault, 1);
        rreg(A_CTRL); check("R12 held frozen", rv, held);
        wreg(A_CTRL, 3);
        rreg(A_CTRL); check("R12 release", rv, 1);

        // R10: data-bank length fault in user mode
        wreg(A_SPLIT, 4);
        wreg(saddr(2, 1, 0, 5), (0 << 8) | 3);
        acc((5 << 13) | (1 << 6), 2, 1, 1, 16'h0F0E);
        check("R10 data fault strobe", fault, 1);
        rreg(A_CTRL);
        check("R10 data status", rv, 1 | (5 << 2) | (1 << 5) | (2 << 6) | (1 << 14));
        rreg(A_FADDR); check("R10 data faddr", rv, 16'h0F0E);
        rreg(saddr(2, 1, 0, 5)); check("R9 no dirty on length fault", rv, 3);

        // R10 R6: read-only flag capture
        wreg(A_CTRL, 3);
        wreg(saddr(0, 0, 0, 3), (127 << 8) | 1);
        acc((3 << 13) | 16'h10, 0, 1, 1, 16'h0042);
        check("R6 ro strobe", fault, 1);
        rreg(A_CTRL); check("R10 ro status", rv, 1 | (3 << 2) | (1 << 13));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule